// File: doc/BRIEF.md
# Burst Memory Wait-State Sequencer

This block paces the data beats of one external memory region. A transaction starts with a request that carries a beat count. The first beat is held back by a programmable number of wait cycles, chosen by a 3-bit code through a nonlinear table. Each later beat of a burst to a burst-capable ROM-like device is held back by a second, linear 3-bit code. When the wait count that applies to a beat is nonzero, the external ready input must also be high before that beat completes. When the count is zero, ready is ignored.

Both codes sit in a 32-bit control word that a neighbouring register block writes. The first-access code is in bits 25:23 and the pitch code is in bits 22:20. The sequencer copies both codes when it accepts a request, so a write to the control word during a transaction has no effect on that transaction.

The sequencer has four states:
- `ST_IDLE`: it waits for a request. `accept` moves it to `ST_FIRST`.
- `ST_FIRST`: it counts the first-access waits. A completed beat moves it to `ST_PITCH`, or to `ST_FINISH` if that was the last beat.
- `ST_PITCH`: it counts the pitch waits of each later beat. It moves to `ST_FINISH` after the last beat.
- `ST_FINISH`: it pulses `done` and returns to `ST_IDLE`.

Top module: `burst_wait_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset the block is idle, with `busy`, `beat_strobe` and `done` low, and both codes are 3'b111. A request that follows reset with no configuration write therefore gets 15 first-access waits and 7 pitch waits.
- R2: The first-access code in `cfg_data[25:23]` selects the wait cycles before the first beat as follows: 0→0, 1→1, 2→2, 3→3, 4→6, 5→9, 6→12, 7→15. With ready high, the first `beat_strobe` comes that many cycles after the first cycle of `busy`.
- R3: The pitch code in `cfg_data[22:20]` gives 0 to 7 wait cycles, equal to its binary value, before each beat from the second onward. With ready high, consecutive strobes are spaced pitch+1 cycles apart.
- R4: A beat whose wait count is zero completes without regard to `rdy_in`.
- R5: A beat whose wait count is nonzero completes only in a cycle where its waits have elapsed and `rdy_in` is high. While `rdy_in` is low, wait cycles are added.
- R6: `req_len` selects the number of beats: 2'b00→1, 2'b01→2, 2'b10→4, 2'b11→8.
- R7: `done` is high for exactly one cycle, in the cycle after the last `beat_strobe`. `busy` is low in the cycle after `done`.
- R8: Both codes are captured when a request is accepted. A configuration write in the accept cycle or later does not change the transaction in progress. It applies from the next request.
- R9: A request is accepted only when the block is idle. A request while busy is dropped and produces no beats.
- R10: Configuration bits outside 25:20 have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_data | input | 32 | Control word; first-access code [25:23], pitch code [22:20] |
| req_valid | input | 1 | Start request (taken only when idle) |
| req_len | input | 2 | Beat count code: 1, 2, 4 or 8 beats |
| rdy_in | input | 1 | External ready |
| busy | output | 1 | Transaction in progress |
| beat_strobe | output | 1 | One cycle per completed data beat |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench sweeps all eight first-access codes, to catch a design that uses the code linearly: such a design would give 4 waits where 6 are due. It checks the spacing of later beats, which shows a design that reuses the first-access count or adds one cycle too many.

With both codes at zero and ready held low, the bench shows whether a design wrongly stalls on ready when no waits are due. With ready held low after a nonzero count has elapsed, it shows whether a design lets the beat through early.

A configuration write that lands in the accept cycle exposes a design that reads the live codes instead of the captured ones. A request pulsed while busy catches a design that restarts or extends the burst. Random ready patterns are compared cycle by cycle against a behavioural model.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int CODE_W = 3;
    localparam int WAIT_W = 4;
    localparam int LEN_W  = 2;
    localparam int BEAT_W = (1 << LEN_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_PITCH,
        ST_FINISH
    } bws_state_e;

    // Codes 0..3 are linear; codes 4..7 step by three cycles (6, 9, 12, 15).
    function automatic logic [WAIT_W-1:0] first_waits(input logic [CODE_W-1:0] code);
        logic [WAIT_W-1:0] c;
        c = WAIT_W'(code);
        if (code[CODE_W-1] == 1'b0)
            first_waits = c;
        else
            first_waits = WAIT_W'(3 * (c - WAIT_W'(2)));
    endfunction

endpackage

// File: rtl/bws_cfg_reg.sv
module bws_cfg_reg #(
    parameter int DATA_W    = 32,
    parameter int FIRST_LSB = 23,
    parameter int PITCH_LSB = 20,
    parameter int CODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] first_code,
    output logic [CODE_W-1:0] pitch_code
);

    localparam logic [CODE_W-1:0] CODE_RST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_code <= CODE_RST;
            pitch_code <= CODE_RST;
        end else if (wr_en) begin
            first_code <= wr_data[FIRST_LSB +: CODE_W];
            pitch_code <= wr_data[PITCH_LSB +: CODE_W];
        end
    end

endmodule

// File: rtl/bws_down_cnt.sv
module bws_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && !zero)
            cnt <= cnt - W'(1);
    end

endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
    import bws_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int FIRST_LSB = 23,
    parameter int PITCH_LSB = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             rdy_in,
    output logic             busy,
    output logic             beat_strobe,
    output logic             done
);

    bws_state_e        state_q, state_d;
    logic [CODE_W-1:0] cfg_first, cfg_pitch;
    logic [CODE_W-1:0] fcode_q, pcode_q;
    logic              accept, in_access, cur_ign, beat_go;
    logic              w_load, w_zero, b_load, b_zero;
    logic [WAIT_W-1:0] w_val, w_cnt;
    logic [BEAT_W-1:0] b_val, b_cnt;

    bws_cfg_reg #(
        .DATA_W   (CFG_W),
        .FIRST_LSB(FIRST_LSB),
        .PITCH_LSB(PITCH_LSB),
        .CODE_W   (CODE_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_data   (cfg_data),
        .first_code(cfg_first),
        .pitch_code(cfg_pitch)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign in_access = (state_q == ST_FIRST) || (state_q == ST_PITCH);
    assign cur_ign   = (state_q == ST_FIRST) ? (fcode_q == '0) : (pcode_q == '0);
    assign beat_go   = in_access && w_zero && (cur_ign || rdy_in);

    // Wait counter: loaded for the first beat on accept, for each later beat on a strobe.
    assign w_load = accept || (beat_go && !b_zero);
    assign w_val  = accept ? first_waits(cfg_first) : WAIT_W'(pcode_q);

    bws_down_cnt #(.W(WAIT_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .load    (w_load),
        .load_val(w_val),
        .dec     (in_access),
        .cnt     (w_cnt),
        .zero    (w_zero)
    );

    // Beat counter holds the number of beats still to come after the current one.
    assign b_load = accept;
    assign b_val  = BEAT_W'((1 << req_len) - 1);

    bws_down_cnt #(.W(BEAT_W)) u_beats (
        .clk     (clk),
        .rst     (rst),
        .load    (b_load),
        .load_val(b_val),
        .dec     (beat_go),
        .cnt     (b_cnt),
        .zero    (b_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fcode_q <= '1;
            pcode_q <= '1;
        end else if (accept) begin
            fcode_q <= cfg_first;
            pcode_q <= cfg_pitch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST,
            ST_PITCH:  if (beat_go) state_d = b_zero ? ST_FINISH : ST_PITCH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        beat_strobe = beat_go;
        done        = (state_q == ST_FINISH);
    end

endmodule

// File: rtl/bws_chk.sv
module bws_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic beat_strobe,
    input logic done,
    input logic req_valid,
    input logic rdy_in,
    input logic cur_ign
);

    // R7
    done_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R7
    no_strobe_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !beat_strobe);

    // R5
    strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_strobe && !cur_ign) |-> rdy_in);

    // R9
    idle_without_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);

    // R1
    strobe_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        beat_strobe |-> busy);

endmodule

bind burst_wait_seq bws_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .beat_strobe(beat_strobe),
    .done       (done),
    .req_valid  (req_valid),
    .rdy_in     (rdy_in),
    .cur_ign    (cur_ign)
);

// File: tb/burst_wait_seq_tb.sv
module burst_wait_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_len = '0;
    logic        rdy_in = 1'b1;
    logic        busy, beat_strobe, done;

    int total = 0;
    int bad = 0;
    bit cmp_en = 1'b0;
    bit rnd_en = 1'b0;

    always #5 clk = ~clk;

    burst_wait_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_data   (cfg_data),
        .req_valid  (req_valid),
        .req_len    (req_len),
        .rdy_in     (rdy_in),
        .busy       (busy),
        .beat_strobe(beat_strobe),
        .done       (done)
    );

    function automatic int fmap(input int c);
        case (c)
            0: return 0;  1: return 1;  2: return 2;  3: return 3;
            4: return 6;  5: return 9;  6: return 12; default: return 15;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 first beat, 2 later beat, 3 finish.
    int m_st = 0, m_w = 0, m_beats = 0, m_fc = 7, m_pc = 7, m_cf = 7, m_cp = 7;

    function automatic bit m_ign();
        return (m_st == 1) ? (m_fc == 0) : (m_pc == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cf = 7; m_cp = 7;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_fc = m_cf; m_pc = m_cp; m_w = fmap(m_cf);
                    m_beats = 1 << req_len; m_st = 1;
                end
                1, 2: if (m_w == 0 && (m_ign() || rdy_in)) begin
                    m_beats--;
                    if (m_beats == 0) m_st = 3;
                    else begin m_w = m_pc; m_st = 2; end
                end else if (m_w > 0) m_w--;
                default: m_st = 0;
            endcase
            if (cfg_we) begin
                m_cf = int'(cfg_data[25:23]);
                m_cp = int'(cfg_data[22:20]);
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            bit eb, es, ed;
            eb = (m_st != 0);
            ed = (m_st == 3);
            es = (m_st == 1 || m_st == 2) && m_w == 0 && (m_ign() || rdy_in);
            check({busy, beat_strobe, done} == {eb, es, ed}, "R4 R5 R7 per-cycle model",
                  int'({busy, beat_strobe, done}), int'({eb, es, ed}));
        end
    end

    always @(posedge clk) begin
        if (rnd_en) begin
            #1 rdy_in = ($urandom % 3) != 0;
        end
    end

    task automatic issue(input bit wr, input logic [31:0] data, input int lc,
                         input bit rv, input bit mid);
        if (wr) begin
            @(posedge clk); #1 cfg_we = 1'b1; cfg_data = data;
        end
        @(posedge clk); #1 cfg_we = 1'b0;
        rdy_in = rv; req_valid = 1'b1; req_len = 2'(lc);
        if (mid) begin cfg_we = 1'b1; cfg_data = 32'h0; end
        @(posedge clk); #1 req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic burst(input bit wr, input logic [31:0] data, input int efc, input int epc,
                         input int lc, input bit rv, input bit mid, input string tag);
        int st[$];
        int cyc, dcyc;
        issue(wr, data, lc, rv, mid);
        cyc = 0; dcyc = -1;
        while (cyc < 400 && dcyc < 0) begin
            @(negedge clk);
            if (beat_strobe) st.push_back(cyc);
            if (done) dcyc = cyc;
            cyc++;
        end
        check(st.size() == (1 << lc), {tag, " R6 beat count"}, st.size(), 1 << lc);
        if (st.size() > 0) begin
            check(st[0] == fmap(efc), {tag, " R2 first-beat waits"}, st[0], fmap(efc));
            for (int i = 1; i < st.size(); i++)
                check(st[i] - st[i-1] == epc + 1, {tag, " R3 pitch spacing"},
                      st[i] - st[i-1], epc + 1);
            check(dcyc == st[st.size()-1] + 1, {tag, " R7 done timing"}, dcyc,
                  st[st.size()-1] + 1);
        end
        @(negedge clk);
        check(busy == 1'b0, {tag, " R7 idle after done"}, int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; cmp_en = 1'b1;
        @(negedge clk);
        check({busy, beat_strobe, done} == 3'b000, "R1 reset outputs",
              int'({busy, beat_strobe, done}), 0);

        // R1: reset codes give 15 first waits and 7 pitch waits
        burst(1'b0, '0, 7, 7, 1, 1'b1, 1'b0, "R1");

        // R2 R3 R10: full code sweep through the documented field positions
        for (int c = 0; c < 8; c++)
            burst(1'b1, (32'(c) << 23) | (32'(7 - c) << 20), c, 7 - c, 1, 1'b1, 1'b0, "R2 R10");

        // R6: every length code
        for (int l = 0; l < 4; l++)
            burst(1'b1, (32'd2 << 23) | (32'd1 << 20), 2, 1, l, 1'b1, 1'b0, "R6");

        // R4: zero waits with ready held low
        burst(1'b1, '0, 0, 0, 3, 1'b0, 1'b0, "R4");

        // R10: every bit outside the fields set, fields zero
        burst(1'b1, 32'hFC0F_FFFF, 0, 0, 2, 1'b0, 1'b0, "R10");

        // R8: write in the accept cycle does not alter the transaction; next one uses it
        burst(1'b1, (32'd3 << 23) | (32'd2 << 20), 3, 2, 2, 1'b1, 1'b1, "R8");
        burst(1'b0, '0, 0, 0, 2, 1'b1, 1'b0, "R8 next request");

        // R5: nonzero count, ready low holds the beat
        issue(1'b1, (32'd1 << 23), 0, 1'b0, 1'b0);
        n = 0;
        repeat (6) begin @(negedge clk); n += int'(beat_strobe); end
        check(n == 0 && busy, "R5 held by low ready", n, 0);
        @(posedge clk); #1 rdy_in = 1'b1;
        @(negedge clk);
        check(beat_strobe == 1'b1, "R5 beat on ready", int'(beat_strobe), 1);
        @(negedge clk);
        check(done == 1'b1, "R5 R7 done follows", int'(done), 1);

        // R9: request while busy is dropped
        issue(1'b1, (32'd3 << 23), 0, 1'b1, 1'b0);
        #1 req_valid = 1'b1; req_len = 2'd3;
        @(posedge clk); #1 req_valid = 1'b0;
        n = 0;
        repeat (12) begin @(negedge clk); n += int'(beat_strobe); end
        check(n == 1, "R9 busy request dropped beats", n, 1);
        check(busy == 1'b0, "R9 stays idle", int'(busy), 0);

        // R5 R4: random ready against the per-cycle model
        rnd_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #2 cfg_we = 1'b1; cfg_data = 32'($urandom);
            @(posedge clk); #2 cfg_we = 1'b0; req_valid = 1'b1; req_len = 2'($urandom % 4);
            @(posedge clk); #2 req_valid = 1'b0;
            while (busy) @(posedge clk);
        end
        rnd_en = 1'b0;
        repeat (4) @(posedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule